// File: doc/BRIEF.md
# Memory Bank Port Responder

This block is the bank side of a request/release memory port. A requester puts an address, byte-write enables and write data on the port and raises a request. The responder checks whether the address belongs to its bank. If it does, the responder latches the request and answers with a series of one-cycle pulses:

- an address release, after which the requester may change its lines;
- on a read, read data qualified by a data gate;
- on a write, a data release;
- on a read or a partial write, a parity verdict;
- finally, a pulse that allows the next request.

A small word array with per-byte odd parity is built in. The block can therefore be exercised on its own, including read-modify-write partial writes, late write cancellation through an abort input, and parity faults planted through an injection input. The bank's base is a port, so one design serves every bank position. Response spacing is set by cycle-count parameters.

Top module: `mbank_responder`

## Requirements
- R1: `addr_here` is high exactly when `addr[7:4]` equals `bank_base`, in the same cycle, whether or not a request is present.
- R2: A request whose address is outside the bank is never serviced: no `addr_rel`, `data_gate`, `data_rel`, `par_err`, `par_ok` or `next_ok` pulse follows it.
- R3: For an accepted request, `addr_rel` is a one-cycle pulse in the (AR_DLY+1)th cycle after the accepting clock edge, where AR_DLY is 2 by default.
- R4: Address, byte enables, write data and the injection flag are captured at acceptance. Changing them after `addr_rel` has no effect on the transaction.
- R5: `byte_we` encodes the operation: 4'b0000 is a read, 4'b1111 a full write, and any other value a partial write. A full write stores the word and gives one `data_rel` pulse DATA_DLY+2 cycles after `addr_rel`, where DATA_DLY is 2 by default.
- R6: A full write produces no parity pulse, and `data_gate` and `data_rel` are never high together.
- R7: A read gives a one-cycle `data_gate` DATA_DLY+2 cycles after `addr_rel`. While the gate is high, `rdata` carries the stored word, and `rdata` is unchanged in the cycle after the gate falls.
- R8: A partial write replaces byte lane b (bits 8b+7:8b) where `byte_we[b]` is 1 and keeps the other lanes. It pulses `data_rel` once, then gives one parity pulse in the next cycle.
- R9: `abort` high in any cycle from acceptance through the `data_rel` cycle leaves the stored word unchanged. `data_rel` and, for a partial write, the parity pulse are still issued.
- R10: Parity is one odd bit per byte. Every read and partial write yields exactly one of `par_err` or `par_ok`, never both, in the cycle after `data_gate` or `data_rel`.
- R11: `inj_par_err` high at acceptance of a write stores lane 0's parity bit inverted, so a later read reports `par_err`. A partial write onto such a word reports `par_err` and rewrites the word with correct parity.
- R12: Every accepted transaction ends with a one-cycle `next_ok` pulse, and a request present in the cycle after it is accepted.
- R13: During and right after reset all pulse outputs are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_base | input | 4 | Upper address bits that select this bank |
| req | input | 1 | Memory request |
| addr | input | 8 | Word address |
| byte_we | input | 4 | Byte-write enables, also the operation code |
| wdata | input | 32 | Write data |
| abort | input | 1 | Cancels a write in progress |
| inj_par_err | input | 1 | Plant a parity fault in the written word |
| addr_here | output | 1 | Address falls in this bank |
| addr_rel | output | 1 | Address release pulse |
| rdata | output | 32 | Read data |
| data_gate | output | 1 | Read data valid pulse |
| data_rel | output | 1 | Write data release pulse |
| par_err | output | 1 | Parity error pulse |
| par_ok | output | 1 | Parity good pulse |
| next_ok | output | 1 | Next request allowed pulse |

## Verification
The bench runs every operation code against distinct words:
- full writes of two different patterns, followed by reads of both, show that one write does not spill into another address;
- a partial write with alternating lane enables separates merging from overwriting;
- the same full and partial writes repeated with abort held show that cancellation stops only the store and not the pulses;
- writes with the injection flag, then a read and a partial write on that word, set the error verdict apart from the good one and show that read-modify-write repairs parity.

Out-of-bank requests and lines scrambled after address release separate decoding and latching from the rest of the sequence.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AREL,
    ST_DATA,
    ST_ACC,
    ST_GATE,
    ST_WR,
    ST_PAR,
    ST_NEXT
  } mbr_state_t;

endpackage

// File: rtl/mbr_match.sv
module mbr_match #(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] addr_sel,
  input  logic [SEL_W-1:0] base,
  output logic             hit
);
  assign hit = (addr_sel == base);
endmodule

// File: rtl/mbr_parity.sv
module mbr_parity #(
  parameter int BYTES = 4
) (
  input  logic [BYTES*8-1:0] data,
  output logic [BYTES-1:0]   par
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign par[b] = ~^data[8*b +: 8];
  end
endmodule

// File: rtl/mbr_store.sv
module mbr_store #(
  parameter int BYTES = 4,
  parameter int IDX_W = 4,
  localparam int WORDS = 1 << IDX_W,
  localparam int DW = BYTES * 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [BYTES-1:0] wr_par,
  output logic [DW-1:0]    rd_data,
  output logic [BYTES-1:0] rd_par
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] dmem [WORDS];
    logic       pmem [WORDS];

    always_ff @(posedge clk) begin
      if (we) begin
        dmem[idx] <= wr_data[8*b +: 8];
        pmem[idx] <= wr_par[b];
      end
    end

    assign rd_data[8*b +: 8] = dmem[idx];
    assign rd_par[b]         = pmem[idx];
  end
endmodule

// File: rtl/mbr_seq.sv
module mbr_seq
  import mbr_pkg::*;
#(
  parameter int BYTES    = 4,
  parameter int IDX_W    = 4,
  parameter int AR_DLY   = 2,
  parameter int DATA_DLY = 2,
  localparam int DW    = BYTES * 8,
  localparam int MAXD  = (AR_DLY > DATA_DLY) ? AR_DLY : DATA_DLY,
  localparam int CNT_W = $clog2(MAXD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  logic [BYTES-1:0] byte_we,
  input  logic [DW-1:0]    wdata,
  input  logic             abort,
  input  logic             inj,
  input  logic [DW-1:0]    mem_rd,
  input  logic             mem_bad,
  output logic [IDX_W-1:0] mem_idx,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wd,
  output logic             mem_flip,
  output logic             addr_rel,
  output logic [DW-1:0]    rdata,
  output logic             data_gate,
  output logic             data_rel,
  output logic             par_err,
  output logic             par_ok,
  output logic             next_ok
);
  localparam logic [CNT_W-1:0] AR_LAST = CNT_W'(AR_DLY - 1);
  localparam logic [CNT_W-1:0] DT_LAST = CNT_W'(DATA_DLY - 1);

  mbr_state_t       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [IDX_W-1:0] idx_q;
  logic [BYTES-1:0] we_q;
  logic [DW-1:0]    wd_q;
  logic [DW-1:0]    old_q;
  logic             abort_q, abort_n;
  logic             inj_q;
  logic             perr_q;
  logic             cap_en, acc_en;
  logic             is_rd, is_full;

  assign cap_en  = (state == ST_IDLE) && req && hit;
  assign acc_en  = (state == ST_ACC);
  assign is_rd   = (we_q == '0);
  assign is_full = (&we_q);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    case (state)
      ST_IDLE: begin
        if (req && hit) begin
          state_n = ST_ADDR;
          cnt_n   = '0;
        end
      end
      ST_ADDR: begin
        if (cnt == AR_LAST) begin
          state_n = ST_AREL;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_AREL: begin
        state_n = ST_DATA;
        cnt_n   = '0;
      end
      ST_DATA: begin
        if (cnt == DT_LAST) begin
          state_n = ST_ACC;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_ACC:  state_n = is_rd ? ST_GATE : ST_WR;
      ST_GATE: state_n = ST_PAR;
      ST_WR:   state_n = is_full ? ST_NEXT : ST_PAR;
      ST_PAR:  state_n = ST_NEXT;
      ST_NEXT: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    if (cap_en) begin
      abort_n = abort;
    end else if (state != ST_IDLE) begin
      abort_n = abort_q | abort;
    end else begin
      abort_n = abort_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      abort_q <= 1'b0;
    end else begin
      state   <= state_n;
      cnt     <= cnt_n;
      abort_q <= abort_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      we_q  <= '0;
      wd_q  <= '0;
      inj_q <= 1'b0;
    end else if (cap_en) begin
      idx_q <= idx;
      we_q  <= byte_we;
      wd_q  <= wdata;
      inj_q <= inj;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q  <= '0;
      perr_q <= 1'b0;
    end else if (acc_en) begin
      old_q  <= mem_rd;
      perr_q <= mem_bad;
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign mem_wd[8*b +: 8] = we_q[b] ? wd_q[8*b +: 8] : old_q[8*b +: 8];
  end

  assign mem_idx   = idx_q;
  assign mem_we    = (state == ST_WR) && !(abort_q || abort);
  assign mem_flip  = inj_q;
  assign addr_rel  = (state == ST_AREL);
  assign data_gate = (state == ST_GATE);
  assign data_rel  = (state == ST_WR);
  assign par_err   = (state == ST_PAR) && perr_q;
  assign par_ok    = (state == ST_PAR) && !perr_q;
  assign next_ok   = (state == ST_NEXT);
  assign rdata     = old_q;
endmodule

// File: rtl/mbank_responder.sv
module mbank_responder #(
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 4,
  parameter int BYTES    = 4,
  parameter int AR_DLY   = 2,
  parameter int DATA_DLY = 2,
  localparam int SEL_W = ADDR_W - IDX_W,
  localparam int DW    = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bank_base,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  byte_we,
  input  logic [DW-1:0]     wdata,
  input  logic              abort,
  input  logic              inj_par_err,
  output logic              addr_here,
  output logic              addr_rel,
  output logic [DW-1:0]     rdata,
  output logic              data_gate,
  output logic              data_rel,
  output logic              par_err,
  output logic              par_ok,
  output logic              next_ok
);
  logic             rst_meta, rst_core_n;
  logic [IDX_W-1:0] mem_idx;
  logic             mem_we, mem_flip, mem_bad;
  logic [DW-1:0]    mem_wd, mem_rd;
  logic [BYTES-1:0] rd_par, rd_par_gen, wr_par_gen, wr_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  mbr_match #(.SEL_W(SEL_W)) u_match (
    .addr_sel (addr[ADDR_W-1:IDX_W]),
    .base     (bank_base),
    .hit      (addr_here)
  );

  mbr_parity #(.BYTES(BYTES)) u_par_rd (
    .data (mem_rd),
    .par  (rd_par_gen)
  );

  mbr_parity #(.BYTES(BYTES)) u_par_wr (
    .data (mem_wd),
    .par  (wr_par_gen)
  );

  assign mem_bad = (rd_par != rd_par_gen);
  assign wr_par  = wr_par_gen ^ {{(BYTES-1){1'b0}}, mem_flip};

  mbr_store #(.BYTES(BYTES), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .we      (mem_we),
    .idx     (mem_idx),
    .wr_data (mem_wd),
    .wr_par  (wr_par),
    .rd_data (mem_rd),
    .rd_par  (rd_par)
  );

  mbr_seq #(
    .BYTES(BYTES), .IDX_W(IDX_W), .AR_DLY(AR_DLY), .DATA_DLY(DATA_DLY)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req       (req),
    .hit       (addr_here),
    .idx       (addr[IDX_W-1:0]),
    .byte_we   (byte_we),
    .wdata     (wdata),
    .abort     (abort),
    .inj       (inj_par_err),
    .mem_rd    (mem_rd),
    .mem_bad   (mem_bad),
    .mem_idx   (mem_idx),
    .mem_we    (mem_we),
    .mem_wd    (mem_wd),
    .mem_flip  (mem_flip),
    .addr_rel  (addr_rel),
    .rdata     (rdata),
    .data_gate (data_gate),
    .data_rel  (data_rel),
    .par_err   (par_err),
    .par_ok    (par_ok),
    .next_ok   (next_ok)
  );
endmodule

// File: rtl/mbank_responder_chk.sv
module mbank_responder_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          addr_rel,
  input logic [DW-1:0] rdata,
  input logic          data_gate,
  input logic          data_rel,
  input logic          par_err,
  input logic          par_ok,
  input logic          next_ok,
  input logic          mem_we
);
  // R3
  ar_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_rel |=> !addr_rel);

  // R7
  gate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_gate |=> !data_gate);

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_gate) |-> $stable(rdata));

  // R6
  rel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_gate && data_rel));

  // R10
  par_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_err && par_ok));

  // R9
  abort_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rel && abort) |-> !mem_we);

  // R12
  next_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_ok |=> !next_ok);
endmodule

bind mbank_responder mbank_responder_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .abort     (abort),
  .addr_rel  (addr_rel),
  .rdata     (rdata),
  .data_gate (data_gate),
  .data_rel  (data_rel),
  .par_err   (par_err),
  .par_ok    (par_ok),
  .next_ok   (next_ok),
  .mem_we    (mem_we)
);

// File: tb/mbank_responder_tb.sv
module mbank_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AR_DLY     = 2;
  localparam int DATA_DLY   = 2;

  logic        clk, rst_n, req, abort, inj;
  logic [3:0]  bank_base, byte_we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        addr_here, addr_rel, data_gate, data_rel, par_err, par_ok, next_ok;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  mbank_responder #(.AR_DLY(AR_DLY), .DATA_DLY(DATA_DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .bank_base(bank_base), .req(req), .addr(addr),
    .byte_we(byte_we), .wdata(wdata), .abort(abort), .inj_par_err(inj),
    .addr_here(addr_here), .addr_rel(addr_rel), .rdata(rdata),
    .data_gate(data_gate), .data_rel(data_rel), .par_err(par_err),
    .par_ok(par_ok), .next_ok(next_ok)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one transaction; results returned through outputs
  task automatic xact(input logic [7:0] a, input logic [3:0] we, input logic [31:0] d,
                      input bit ab, input bit pi,
                      output int ar_cyc, output int step, output logic [31:0] rd,
                      output logic [31:0] rd_after, output int n_gate, output int n_dr,
                      output int n_pe, output int n_pok, output int n_next);
    int cyc;
    int ar_at;
    bit gate_prev;
    n_gate = 0; n_dr = 0; n_pe = 0; n_pok = 0; n_next = 0;
    step = -1; ar_cyc = -1; ar_at = 0; rd = '0; rd_after = '0; gate_prev = 1'b0;
    @(negedge clk);
    req = 1'b1; addr = a; byte_we = we; wdata = d; abort = ab; inj = pi;
    cyc = 0;
    while (cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (gate_prev) rd_after = rdata;
      gate_prev = data_gate;
      if (addr_rel) begin
        ar_cyc = cyc; ar_at = cyc;
        req = 1'b0; addr = a ^ 8'h01; byte_we = ~we; wdata = ~d; inj = 1'b0;
      end
      if (data_gate) begin n_gate++; rd = rdata; step = cyc - ar_at; end
      if (data_rel) begin n_dr++; step = cyc - ar_at; end
      if (par_err) n_pe++;
      if (par_ok) n_pok++;
      if (next_ok) begin n_next++; break; end
    end
    abort = 1'b0;
  endtask

  int ar, st, ng, nd, npe, npok, nnx;
  logic [31:0] rd, rda;

  task automatic do_write(input logic [7:0] a, input logic [3:0] we, input logic [31:0] d,
                          input bit ab, input bit pi);
    xact(a, we, d, ab, pi, ar, st, rd, rda, ng, nd, npe, npok, nnx);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] v);
    xact(a, 4'h0, 32'h0, 1'b0, 1'b0, ar, st, rd, rda, ng, nd, npe, npok, nnx);
    v = rd;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 1'b0; abort = 1'b0; inj = 1'b0; bank_base = 4'h3;
    addr = 8'h00; byte_we = 4'h0; wdata = '0;
    repeat (3) @(negedge clk);
    chk({addr_rel, data_gate, data_rel, par_err, par_ok, next_ok} == 6'b0 && rdata == 0,
        "R13 outputs in reset", {26'b0, addr_rel, data_gate, data_rel, par_err, par_ok, next_ok}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({addr_rel, data_gate, data_rel, par_err, par_ok, next_ok} == 6'b0 && rdata == 0,
        "R13 outputs after reset", rdata, 0);
  endtask

  task automatic t_decode();
    addr = 8'h35; #1;
    chk(addr_here == 1'b1, "R1 in-bank address", {31'b0, addr_here}, 1);
    addr = 8'h45; #1;
    chk(addr_here == 1'b0, "R1 above bank", {31'b0, addr_here}, 0);
    addr = 8'h2F; #1;
    chk(addr_here == 1'b0, "R1 below bank", {31'b0, addr_here}, 0);
    bank_base = 4'h4; addr = 8'h45; #1;
    chk(addr_here == 1'b1, "R1 moved base", {31'b0, addr_here}, 1);
    bank_base = 4'h3; addr = 8'h00;
  endtask

  task automatic t_miss();
    int seen;
    seen = 0;
    @(negedge clk);
    req = 1'b1; addr = 8'h45; byte_we = 4'hF; wdata = 32'hDEAD_BEEF;
    repeat (12) begin
      @(negedge clk);
      if (addr_rel || data_gate || data_rel || par_err || par_ok || next_ok) seen++;
    end
    req = 1'b0;
    chk(seen == 0, "R2 out-of-bank request ignored", seen, 0);
  endtask

  task automatic t_write_read();
    logic [31:0] v;
    do_write(8'h30, 4'hF, 32'h0BAD_F00D, 1'b0, 1'b0);
    do_write(8'h31, 4'hF, 32'hA5A5_1234, 1'b0, 1'b0);
    chk(ar == AR_DLY + 1, "R3 address release latency", ar, AR_DLY + 1);
    chk(nd == 1 && st == DATA_DLY + 2, "R5 data release once and on time", {nd[15:0], st[15:0]}, {16'd1, 16'(DATA_DLY + 2)});
    chk(npe + npok == 0, "R6 no parity pulse on full write", npe + npok, 0);
    chk(nnx == 1, "R12 next allowed after write", nnx, 1);
    do_read(8'h31, v);
    chk(v == 32'hA5A5_1234, "R5 read back full write", v, 32'hA5A5_1234);
    chk(ng == 1 && st == DATA_DLY + 2 && nd == 0, "R7 data gate single and on time", {ng[15:0], st[15:0]}, {16'd1, 16'(DATA_DLY + 2)});
    chk(rda == v, "R7 rdata held after gate falls", rda, v);
    chk(npok == 1 && npe == 0, "R10 read reports parity ok", {npe[15:0], npok[15:0]}, 32'h0000_0001);
    do_read(8'h30, v);
    chk(v == 32'h0BAD_F00D, "R4 scrambled lines after release ignored", v, 32'h0BAD_F00D);
    chk(ar == AR_DLY + 1, "R12 back-to-back request accepted", ar, AR_DLY + 1);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    do_write(8'h32, 4'hF, 32'h1122_3344, 1'b0, 1'b0);
    do_write(8'h32, 4'b0101, 32'hAABB_CCDD, 1'b0, 1'b0);
    chk(nd == 1 && npok == 1 && npe == 0, "R8 partial write pulses", {nd[15:0], npok[15:0]}, 32'h0001_0001);
    do_read(8'h32, v);
    chk(v == 32'h11BB_33DD, "R8 partial write merge", v, 32'h11BB_33DD);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    do_write(8'h32, 4'hF, 32'hFFFF_0000, 1'b1, 1'b0);
    chk(nd == 1, "R9 data release still issued on abort", nd, 1);
    do_read(8'h32, v);
    chk(v == 32'h11BB_33DD, "R9 aborted full write", v, 32'h11BB_33DD);
    do_write(8'h32, 4'b0011, 32'h0000_9999, 1'b1, 1'b0);
    chk(npe + npok == 1, "R9 aborted partial write still reports parity", npe + npok, 1);
    do_read(8'h32, v);
    chk(v == 32'h11BB_33DD, "R9 aborted partial write", v, 32'h11BB_33DD);
  endtask

  task automatic t_inject();
    logic [31:0] v;
    do_write(8'h33, 4'hF, 32'h0102_0304, 1'b0, 1'b1);
    do_read(8'h33, v);
    chk(npe == 1 && npok == 0, "R11 injected fault reported on read", {npe[15:0], npok[15:0]}, 32'h0001_0000);
    chk(v == 32'h0102_0304, "R11 data intact despite fault", v, 32'h0102_0304);
    do_write(8'h33, 4'b0001, 32'h0000_00FF, 1'b0, 1'b0);
    chk(npe == 1 && npok == 0, "R11 partial write checks old word", {npe[15:0], npok[15:0]}, 32'h0001_0000);
    do_read(8'h33, v);
    chk(npok == 1 && npe == 0 && v == 32'h0102_03FF, "R11 partial write repairs parity", v, 32'h0102_03FF);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_miss();
    t_write_read();
    t_partial();
    t_abort();
    t_inject();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule